// File: doc/BRIEF.md
# Chainable Serial Wiper Setting Register

This block is the digital control front end of a two-channel, 256-step digital potentiometer. A host loads it over a three-wire serial link: a transaction enable (`xfer_en_i`), a serial clock (`ser_clk_i`) and a serial data input (`ser_dat_i`). Bits pass through a 17-bit frame register. When the enable drops, the frame is committed to two 8-bit tap codes and a one-bit bank select. Only these committed values leave the block.

The last frame position drives the cascade output `chain_o`. This output can feed the data input of an identical unit, so a chain of N units takes 17×N serial clocks per transaction. When a transaction opens, the frame is preloaded from the live settings. If the host ties the last unit's `chain_o` back to the first unit's data input and applies exactly 17×N clocks, it reads every setting out without changing any of them. All three serial inputs are asynchronous. They are sampled in the system clock domain through synchronizer flops, and edges are detected there.

Top module: `potctl_top`

## Requirements
- R1: After the synchronous reset, both tap codes are 128, bank select is 0 and `chain_o` is 0.
- R2: While the synchronized enable is low, `chain_o` equals the committed bank select bit.
- R3: A frame is sent as the bank select bit first, then tap 1 MSB-first, then tap 0 MSB-first, one bit per rising serial clock. After 17 bits and a falling enable, bank select, tap 1 and tap 0 take those values.
- R4: During a transaction the committed outputs keep their values. They change only after the enable falls.
- R5: When the enable rises, `chain_o` shows the current bank select bit. After each later serial clock rise it shows the next stored bit: tap 1 MSB downward, then tap 0.
- R6: Serial clock edges while the enable is low change neither the outputs nor the frame contents.
- R7: In a chain of two units, the first 17 of 34 bits land in the downstream unit and the last 17 land in the upstream unit.
- R8: With the last unit's `chain_o` looped back to the first unit's data input, 17×N clocks stream out every stored bit and leave all settings unchanged.
- R9: Tap codes 0 and 255 are stored and returned exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_en_i | input | 1 | Transaction enable, asynchronous, active high |
| ser_clk_i | input | 1 | Serial clock, asynchronous; shifts on rising edge |
| ser_dat_i | input | 1 | Serial data input |
| chain_o | output | 1 | Cascade output: last frame position, or bank select when idle |
| bank_sel_o | output | 1 | Committed bank select bit |
| tap1_o | output | TAP_W | Committed tap code of wiper 1 |
| tap0_o | output | TAP_W | Committed tap code of wiper 0 |

## Verification
The bench uses the default build: TAP_W of 8, which gives 17-bit frames and a reset tap of 128, and two synchronizer stages. It instantiates two units with the cascade output of the first wired to the data input of the second. This brings 34-bit chain writes and the full two-unit loopback read within reach, along with full-scale codes 0 and 255 and the stream order on the cascade output.

// File: rtl/potctl_pkg.sv
package potctl_pkg;
  localparam int unsigned LANE_EN   = 0;
  localparam int unsigned LANE_CLK  = 1;
  localparam int unsigned LANE_DAT  = 2;
  localparam int unsigned NUM_LANES = 3;

  function automatic int unsigned frame_width(input int unsigned tap_w);
    return 2 * tap_w + 1;
  endfunction
endpackage

// File: rtl/potctl_sync.sv
module potctl_sync #(
  parameter int unsigned LANES  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] async_i,
  output logic [LANES-1:0] sync_o
);
  logic [LANES-1:0] stage_q [STAGES];

  genvar gs;
  generate
    for (gs = 0; gs < STAGES; gs++) begin : g_stage
      if (gs == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[gs] <= '0;
          else     stage_q[gs] <= stage_q[gs-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/potctl_shreg.sv
module potctl_shreg #(
  parameter int unsigned FRAME_W = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] load_val_i,
  input  logic               shift_i,
  input  logic               din_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk) begin
    if (rst)          frame_q <= '0;
    else if (load_i)  frame_q <= load_val_i;
    else if (shift_i) frame_q <= {frame_q[FRAME_W-2:0], din_i};
  end

  assign frame_o = frame_q;

  AST_SHIFT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (shift_i && !load_i) |=> (frame_q[FRAME_W-1:1] == $past(frame_q[FRAME_W-2:0])
                              && frame_q[0] == $past(din_i))); // R3
  AST_PRELOAD: assert property (@(posedge clk) disable iff (rst)
    load_i |=> frame_q == $past(load_val_i)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !shift_i) |=> $stable(frame_q)); // R6
endmodule

// File: rtl/potctl_regs.sv
module potctl_regs #(
  parameter int unsigned TAP_W     = 8,
  parameter int unsigned RESET_TAP = 128,
  localparam int unsigned FRAME_W  = 2 * TAP_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               sel_o,
  output logic [TAP_W-1:0]   tap1_o,
  output logic [TAP_W-1:0]   tap0_o
);
  logic             sel_q;
  logic [TAP_W-1:0] tap1_q, tap0_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      tap1_q <= TAP_W'(RESET_TAP);
      tap0_q <= TAP_W'(RESET_TAP);
    end else if (commit_i) begin
      sel_q  <= frame_i[FRAME_W-1];
      tap1_q <= frame_i[FRAME_W-2:TAP_W];
      tap0_q <= frame_i[TAP_W-1:0];
    end
  end

  assign sel_o  = sel_q;
  assign tap1_o = tap1_q;
  assign tap0_o = tap0_q;

  AST_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tap0_q == TAP_W'(RESET_TAP) && tap1_q == TAP_W'(RESET_TAP)
                    && !sel_q)); // R1
  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> ($stable(tap0_q) && $stable(tap1_q) && $stable(sel_q))); // R4
  AST_COMMIT_FIELDS: assert property (@(posedge clk) disable iff (rst)
    commit_i |=> (sel_q == $past(frame_i[FRAME_W-1])
                  && tap0_q == $past(frame_i[TAP_W-1:0]))); // R3
endmodule

// File: rtl/potctl_top.sv
module potctl_top #(
  parameter int unsigned TAP_W       = 8,
  parameter int unsigned RESET_TAP   = 128,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_en_i,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  output logic             chain_o,
  output logic             bank_sel_o,
  output logic [TAP_W-1:0] tap1_o,
  output logic [TAP_W-1:0] tap0_o
);
  import potctl_pkg::*;

  localparam int unsigned FRAME_W = frame_width(TAP_W);

  logic [NUM_LANES-1:0] raw_lanes, sync_lanes;
  logic                 en_lvl, en_prev_q, sclk_lvl, sclk_prev_q, dat_lvl;
  logic                 en_rise, en_fall, sclk_rise, shift_en;
  logic [FRAME_W-1:0]   frame, live_frame;
  logic                 sel_q;
  logic [TAP_W-1:0]     tap1_q, tap0_q;

  always_comb begin
    raw_lanes           = '0;
    raw_lanes[LANE_EN]  = xfer_en_i;
    raw_lanes[LANE_CLK] = ser_clk_i;
    raw_lanes[LANE_DAT] = ser_dat_i;
  end

  potctl_sync #(.LANES(NUM_LANES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(raw_lanes), .sync_o(sync_lanes)
  );

  assign en_lvl   = sync_lanes[LANE_EN];
  assign sclk_lvl = sync_lanes[LANE_CLK];
  assign dat_lvl  = sync_lanes[LANE_DAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_prev_q   <= 1'b0;
      sclk_prev_q <= 1'b0;
    end else begin
      en_prev_q   <= en_lvl;
      sclk_prev_q <= sclk_lvl;
    end
  end

  assign en_rise   = en_lvl & ~en_prev_q;
  assign en_fall   = ~en_lvl & en_prev_q;
  assign sclk_rise = sclk_lvl & ~sclk_prev_q;
  assign shift_en  = sclk_rise & en_lvl & en_prev_q;

  assign live_frame = {sel_q, tap1_q, tap0_q};

  potctl_shreg #(.FRAME_W(FRAME_W)) u_shreg (
    .clk(clk), .rst(rst),
    .load_i(en_rise), .load_val_i(live_frame),
    .shift_i(shift_en), .din_i(dat_lvl),
    .frame_o(frame)
  );

  potctl_regs #(.TAP_W(TAP_W), .RESET_TAP(RESET_TAP)) u_regs (
    .clk(clk), .rst(rst), .commit_i(en_fall), .frame_i(frame),
    .sel_o(sel_q), .tap1_o(tap1_q), .tap0_o(tap0_q)
  );

  assign chain_o    = en_lvl ? frame[FRAME_W-1] : sel_q;
  assign bank_sel_o = sel_q;
  assign tap1_o     = tap1_q;
  assign tap0_o     = tap0_q;

  AST_NO_SHIFT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en_lvl |=> $stable(frame)); // R6
  AST_IDLE_CHAIN: assert property (@(posedge clk) disable iff (rst)
    (!en_lvl && !en_prev_q) |-> chain_o == bank_sel_o); // R2
  AST_OPEN_SHOWS_SEL: assert property (@(posedge clk) disable iff (rst)
    en_rise |=> (chain_o == $past(bank_sel_o) || !en_lvl)); // R5
endmodule

// File: tb/potctl_top_tb.sv
module potctl_top_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, sclk = 1'b0, din = 1'b0, loop = 1'b0;
  logic up_chain, up_sel, dn_chain, dn_sel, up_din;
  logic [7:0] up_t1, up_t0, dn_t1, dn_t0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign up_din = loop ? dn_chain : din;

  potctl_top u_dut (
    .clk(clk), .rst(rst), .xfer_en_i(en), .ser_clk_i(sclk), .ser_dat_i(up_din),
    .chain_o(up_chain), .bank_sel_o(up_sel), .tap1_o(up_t1), .tap0_o(up_t0)
  );
  potctl_top u_nxt (
    .clk(clk), .rst(rst), .xfer_en_i(en), .ser_clk_i(sclk), .ser_dat_i(up_chain),
    .chain_o(dn_chain), .bank_sel_o(dn_sel), .tap1_o(dn_t1), .tap0_o(dn_t0)
  );

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_clk(input logic b);
    din = b;
    wait_cyc(2);
    sclk = 1'b1;
    wait_cyc(5);
    sclk = 1'b0;
    wait_cyc(3);
  endtask

  task automatic open_xfer();
    en = 1'b1;
    wait_cyc(6);
  endtask

  task automatic close_xfer();
    en = 1'b0;
    wait_cyc(6);
  endtask

  task automatic send17(input logic [16:0] f);
    for (int i = 16; i >= 0; i--) pulse_clk(f[i]);
  endtask

  task automatic check_up(input string req, input logic [16:0] f);
    chk(req, {15'd0, up_sel, up_t1, up_t0}, {15'd0, f});
  endtask

  task automatic check_dn(input string req, input logic [16:0] f);
    chk(req, {15'd0, dn_sel, dn_t1, dn_t0}, {15'd0, f});
  endtask

  task automatic t_reset();
    check_up("R1 upstream reset", {1'b0, 8'd128, 8'd128});
    check_dn("R1 downstream reset", {1'b0, 8'd128, 8'd128});
    chk("R1 chain_o reset", up_chain, 0);
  endtask

  task automatic t_write_single();
    logic [16:0] f = {1'b1, 8'hA5, 8'h3C};
    open_xfer();
    for (int i = 16; i >= 7; i--) pulse_clk(f[i]);
    check_up("R4 outputs held mid-transaction", {1'b0, 8'd128, 8'd128});
    for (int i = 6; i >= 0; i--) pulse_clk(f[i]);
    check_up("R4 outputs held before enable falls", {1'b0, 8'd128, 8'd128});
    close_xfer();
    check_up("R3 single frame commit", f);
    chk("R2 idle chain_o shows bank select", up_chain, 1);
  endtask

  task automatic t_ignore_idle();
    din = 1'b0;
    for (int i = 0; i < 5; i++) pulse_clk(1'b0);
    check_up("R6 idle clocks leave outputs", {1'b1, 8'hA5, 8'h3C});
    chk("R6 idle clocks leave chain_o", up_chain, 1);
  endtask

  task automatic t_stream_order();
    logic [16:0] f = {1'b1, 8'hA5, 8'h3C};
    open_xfer();
    chk("R5 first bit out is bank select", up_chain, f[16]);
    for (int i = 15; i >= 8; i--) begin
      pulse_clk(1'b0);
      chk("R5 tap1 bit order on chain_o", up_chain, f[i]);
    end
    close_xfer();
    check_up("R5 partial shift commits shifted frame", {f[8:0], 8'h00});
  endtask

  task automatic t_boundary();
    logic [16:0] f = {1'b0, 8'hFF, 8'h00};
    open_xfer();
    send17(f);
    close_xfer();
    check_up("R9 codes 255 and 0", f);
    chk("R2 idle chain_o after sel cleared", up_chain, 0);
  endtask

  task automatic t_chain();
    logic [16:0] fd = {1'b1, 8'h12, 8'hFE};
    logic [16:0] fu = {1'b0, 8'h81, 8'h7F};
    open_xfer();
    send17(fd);
    send17(fu);
    close_xfer();
    check_dn("R7 downstream gets first frame", fd);
    check_up("R7 upstream gets last frame", fu);
  endtask

  task automatic t_loopback();
    logic [33:0] exp_stream = {1'b1, 8'h12, 8'hFE, 1'b0, 8'h81, 8'h7F};
    logic [33:0] got;
    loop = 1'b1;
    open_xfer();
    for (int i = 33; i >= 0; i--) begin
      got[i] = dn_chain;
      pulse_clk(1'b0);
    end
    close_xfer();
    loop = 1'b0;
    chk("R8 loopback read stream", got, exp_stream);
    check_dn("R8 downstream unchanged", {1'b1, 8'h12, 8'hFE});
    check_up("R8 upstream unchanged", {1'b0, 8'h81, 8'h7F});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);
    t_reset();
    t_write_single();
    t_ignore_idle();
    t_stream_order();
    t_boundary();
    t_chain();
    t_loopback();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule